// File: doc/BRIEF.md
# Branch Decode and Next-PC Unit

A purely combinational unit that takes one 32-bit control-transfer instruction word and the current 64-bit program counter, and resolves where execution goes next. It evaluates six two-register comparisons, compare-with-zero tests and tests on one of eight floating-point condition flags. It also handles unconditional jumps, jump-and-link and register-indirect jump-and-link. For each word it reports the next PC, whether control is redirected, an optional link-register write and an illegal flag.

Offsets are signed word counts. In most formats they are split across separate bit ranges of the word, and the unit joins them back together before use. The surrounding pipeline reads the two source registers named by bits 9:5 and 4:0 and presents their values. It then applies the link write and steers fetch with the next PC.

Top module: `bru_next_pc`

## Requirements
- R1: Major opcode is bits 31:26. Opcodes 010110, 010111, 011000, 011001, 011010 and 011011 are two-register branches that compare operand A (register at bits 9:5) with operand B (register at bits 4:0). Their conditions are, in that order: equal, not equal, signed A<B, signed A>=B, unsigned A<B and unsigned A>=B. Their 16-bit word offset sits in bits 25:10.
- R2: Opcode 010000 branches when operand A is zero and opcode 010001 branches when it is nonzero. Their 21-bit offset is {bits 4:0, bits 25:10}.
- R3: Opcode 010010 is a flag branch. Bits 7:5 select one of the eight condition flags. Bits 9:8 = 00 branch when that flag is 0, and 01 branch when it is 1. The offset is laid out as in R2.
- R4: Opcode 010100 is an unconditional jump and opcode 010101 is a jump that also writes PC+4 to register 1. Their 26-bit offset is {bits 9:0, bits 25:10}.
- R5: Opcode 010011 jumps to operand A + offset×4, with the 16-bit offset in bits 25:10. It writes PC+4 to the register indexed by bits 4:0. The target uses the operand value read before the write, even when both indices are the same.
- R6: A taken transfer with a PC-relative target goes to PC + sign-extended offset×4, computed modulo 2^64. A branch that is not taken goes to PC+4.
- R7: A link write whose index is 0 is suppressed (the write enable stays low).
- R8: Any other major opcode, and a flag branch whose bits 9:8 are 10 or 11, raise illegal. An illegal word leaves taken low and the link write off, and the next PC is PC+4.
- R9: The three jump opcodes of R4 and R5 always report taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pc_i | input | 64 | Address of the instruction |
| instr_i | input | 32 | Instruction word |
| opnd_a_i | input | 64 | Value of the register indexed by bits 9:5 |
| opnd_b_i | input | 64 | Value of the register indexed by bits 4:0 |
| cflags_i | input | 8 | Floating-point condition flags |
| next_pc_o | output | 64 | Address of the next instruction |
| taken_o | output | 1 | Control flow is redirected |
| link_we_o | output | 1 | Link register write enable |
| link_idx_o | output | 5 | Link register index |
| link_data_o | output | 64 | Link value (PC+4) |
| illegal_o | output | 1 | Instruction word not recognised |

## Verification
A redirect and a link write can happen on the same word. Both register-indirect jump-and-link and jump-and-link produce both results at once. The hardest case is a register-indirect jump whose destination index equals its base index. The bench sets up that collision and checks that the target is built from the presented operand value, while the link data is PC+4 and the write goes to the shared index. A second overlap pairs a jump with a link index of 0: the redirect must still happen while the write is suppressed.

// File: rtl/bru_pkg.sv
package bru_pkg;
  localparam int unsigned XLEN   = 64;
  localparam int unsigned ILEN   = 32;
  localparam int unsigned NFLAG  = 8;
  localparam int unsigned FIDX_W = $clog2(NFLAG);
  localparam int unsigned RIDX_W = 5;

  localparam logic [5:0] OP_CEQ   = 6'b010110;
  localparam logic [5:0] OP_CNE   = 6'b010111;
  localparam logic [5:0] OP_CLT   = 6'b011000;
  localparam logic [5:0] OP_CGE   = 6'b011001;
  localparam logic [5:0] OP_CLTU  = 6'b011010;
  localparam logic [5:0] OP_CGEU  = 6'b011011;
  localparam logic [5:0] OP_ZERO  = 6'b010000;
  localparam logic [5:0] OP_NZERO = 6'b010001;
  localparam logic [5:0] OP_FLAG  = 6'b010010;
  localparam logic [5:0] OP_IND   = 6'b010011;
  localparam logic [5:0] OP_JMP   = 6'b010100;
  localparam logic [5:0] OP_JLINK = 6'b010101;

  localparam logic [RIDX_W-1:0] LINK_REG = 5'd1;

  typedef enum logic [2:0] {
    K_COND, K_JMP, K_JLINK, K_IND, K_BAD
  } kind_e;

  typedef enum logic [3:0] {
    C_EQ, C_NE, C_LT, C_GE, C_LTU, C_GEU,
    C_ZERO, C_NZERO, C_FCLR, C_FSET, C_ALWAYS, C_NEVER
  } cond_e;
endpackage

// File: rtl/bru_decode.sv
module bru_decode
  import bru_pkg::*;
#(
  parameter int unsigned W = XLEN
) (
  input  logic [ILEN-1:0]   instr_i,
  output kind_e             kind_o,
  output cond_e             cond_o,
  output logic [W-1:0]      woff_o,
  output logic [FIDX_W-1:0] fidx_o
);
  logic [W-1:0] off16, off21, off26;

  assign off16  = {{(W-16){instr_i[25]}}, instr_i[25:10]};
  assign off21  = {{(W-21){instr_i[4]}},  instr_i[4:0], instr_i[25:10]};
  assign off26  = {{(W-26){instr_i[9]}},  instr_i[9:0], instr_i[25:10]};
  assign fidx_o = instr_i[5 +: FIDX_W];

  always_comb begin
    kind_o = K_BAD;
    cond_o = C_NEVER;
    woff_o = '0;
    case (instr_i[31:26])
      OP_CEQ:   begin kind_o = K_COND;  cond_o = C_EQ;     woff_o = off16; end
      OP_CNE:   begin kind_o = K_COND;  cond_o = C_NE;     woff_o = off16; end
      OP_CLT:   begin kind_o = K_COND;  cond_o = C_LT;     woff_o = off16; end
      OP_CGE:   begin kind_o = K_COND;  cond_o = C_GE;     woff_o = off16; end
      OP_CLTU:  begin kind_o = K_COND;  cond_o = C_LTU;    woff_o = off16; end
      OP_CGEU:  begin kind_o = K_COND;  cond_o = C_GEU;    woff_o = off16; end
      OP_ZERO:  begin kind_o = K_COND;  cond_o = C_ZERO;   woff_o = off21; end
      OP_NZERO: begin kind_o = K_COND;  cond_o = C_NZERO;  woff_o = off21; end
      OP_FLAG: begin
        woff_o = off21;
        case (instr_i[9:8])
          2'b00:   begin kind_o = K_COND; cond_o = C_FCLR; end
          2'b01:   begin kind_o = K_COND; cond_o = C_FSET; end
          default: begin kind_o = K_BAD;  cond_o = C_NEVER; end
        endcase
      end
      OP_JMP:   begin kind_o = K_JMP;   cond_o = C_ALWAYS; woff_o = off26; end
      OP_JLINK: begin kind_o = K_JLINK; cond_o = C_ALWAYS; woff_o = off26; end
      OP_IND:   begin kind_o = K_IND;   cond_o = C_ALWAYS; woff_o = off16; end
      default:  begin kind_o = K_BAD;   cond_o = C_NEVER;  woff_o = '0;    end
    endcase
  end
endmodule

// File: rtl/bru_cond.sv
module bru_cond
  import bru_pkg::*;
#(
  parameter int unsigned W = XLEN,
  parameter int unsigned NF = NFLAG
) (
  input  cond_e                  cond_i,
  input  logic [W-1:0]           a_i,
  input  logic [W-1:0]           b_i,
  input  logic [NF-1:0]          flags_i,
  input  logic [$clog2(NF)-1:0]  fidx_i,
  output logic                   hit_o
);
  logic eq, lts, ltu, sel_flag;

  assign eq       = (a_i == b_i);
  assign lts      = ($signed(a_i) < $signed(b_i));
  assign ltu      = (a_i < b_i);
  assign sel_flag = flags_i[fidx_i];

  always_comb begin
    case (cond_i)
      C_EQ:     hit_o = eq;
      C_NE:     hit_o = !eq;
      C_LT:     hit_o = lts;
      C_GE:     hit_o = !lts;
      C_LTU:    hit_o = ltu;
      C_GEU:    hit_o = !ltu;
      C_ZERO:   hit_o = (a_i == '0);
      C_NZERO:  hit_o = (a_i != '0);
      C_FCLR:   hit_o = !sel_flag;
      C_FSET:   hit_o = sel_flag;
      C_ALWAYS: hit_o = 1'b1;
      default:  hit_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/bru_target.sv
module bru_target #(
  parameter int unsigned W = 64
) (
  input  logic [W-1:0] base_i,
  input  logic [W-1:0] woff_i,
  output logic [W-1:0] tgt_o
);
  localparam int unsigned SHIFT = 2;
  assign tgt_o = base_i + {woff_i[W-SHIFT-1:0], {SHIFT{1'b0}}};
endmodule

// File: rtl/bru_next_pc.sv
module bru_next_pc
  import bru_pkg::*;
(
  input  logic [XLEN-1:0]   pc_i,
  input  logic [ILEN-1:0]   instr_i,
  input  logic [XLEN-1:0]   opnd_a_i,
  input  logic [XLEN-1:0]   opnd_b_i,
  input  logic [NFLAG-1:0]  cflags_i,
  output logic [XLEN-1:0]   next_pc_o,
  output logic              taken_o,
  output logic              link_we_o,
  output logic [RIDX_W-1:0] link_idx_o,
  output logic [XLEN-1:0]   link_data_o,
  output logic              illegal_o
);
  localparam logic [XLEN-1:0] ISTEP = XLEN'(ILEN / 8);

  kind_e             kind;
  cond_e             cond;
  logic [XLEN-1:0]   woff, base, tgt, seq;
  logic [FIDX_W-1:0] fidx;
  logic              hit, wants_link;

  bru_decode #(.W(XLEN)) u_decode (
    .instr_i (instr_i), .kind_o (kind), .cond_o (cond),
    .woff_o  (woff),    .fidx_o (fidx)
  );

  bru_cond #(.W(XLEN), .NF(NFLAG)) u_cond (
    .cond_i (cond), .a_i (opnd_a_i), .b_i (opnd_b_i),
    .flags_i (cflags_i), .fidx_i (fidx), .hit_o (hit)
  );

  assign base = (kind == K_IND) ? opnd_a_i : pc_i;

  bru_target #(.W(XLEN)) u_target (
    .base_i (base), .woff_i (woff), .tgt_o (tgt)
  );

  assign seq = pc_i + ISTEP;

  always_comb begin
    wants_link = 1'b0;
    link_idx_o = '0;
    case (kind)
      K_JLINK: begin wants_link = 1'b1; link_idx_o = LINK_REG; end
      K_IND:   begin wants_link = 1'b1; link_idx_o = instr_i[RIDX_W-1:0]; end
      default: begin wants_link = 1'b0; link_idx_o = '0; end
    endcase
  end

  assign link_we_o   = wants_link && (link_idx_o != '0);
  assign link_data_o = seq;
  assign taken_o     = hit;
  assign next_pc_o   = hit ? tgt : seq;
  assign illegal_o   = (kind == K_BAD);
endmodule

// File: rtl/bru_next_pc_chk.sv
module bru_next_pc_chk
  import bru_pkg::*;
(
  input logic [XLEN-1:0]   pc_i,
  input logic [ILEN-1:0]   instr_i,
  input logic [XLEN-1:0]   next_pc_o,
  input logic              taken_o,
  input logic              link_we_o,
  input logic [RIDX_W-1:0] link_idx_o,
  input logic [XLEN-1:0]   link_data_o,
  input logic              illegal_o
);
  logic [5:0] op;
  assign op = instr_i[31:26];

  always_comb begin
    // R8: illegal word falls through with no side effects
    a_r8_illegal_quiet: assert (!illegal_o ||
      (next_pc_o == pc_i + 64'd4 && !taken_o && !link_we_o));
    // R6: not taken means sequential
    a_r6_fallthrough: assert (taken_o || next_pc_o == pc_i + 64'd4);
    // R6: PC-relative targets keep word alignment relative to PC
    a_r6_word_step: assert (op == OP_IND || next_pc_o[1:0] == pc_i[1:0]);
    // R7: register 0 is never written
    a_r7_no_zero_link: assert (!link_we_o || link_idx_o != '0);
    // R4: jump-and-link writes PC+4 to register 1
    a_r4_link_reg: assert (op != OP_JLINK ||
      (link_we_o && link_idx_o == LINK_REG && link_data_o == pc_i + 64'd4));
    // R9: jumps are always taken
    a_r9_jump_taken: assert (!(op == OP_JMP || op == OP_JLINK || op == OP_IND) || taken_o);
  end
endmodule

bind bru_next_pc bru_next_pc_chk u_chk (
  .pc_i (pc_i), .instr_i (instr_i), .next_pc_o (next_pc_o),
  .taken_o (taken_o), .link_we_o (link_we_o), .link_idx_o (link_idx_o),
  .link_data_o (link_data_o), .illegal_o (illegal_o)
);

// File: tb/bru_next_pc_tb.sv
module bru_next_pc_tb;
  logic        clk;
  logic [63:0] pc, a, b, next_pc, link_data;
  logic [31:0] instr;
  logic [7:0]  flags;
  logic        taken, link_we, illegal;
  logic [4:0]  link_idx;
  int          n_chk, n_fail;
  bit          done;

  bru_next_pc u_dut (
    .pc_i (pc), .instr_i (instr), .opnd_a_i (a), .opnd_b_i (b),
    .cflags_i (flags), .next_pc_o (next_pc), .taken_o (taken),
    .link_we_o (link_we), .link_idx_o (link_idx),
    .link_data_o (link_data), .illegal_o (illegal)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] enc_cmp(input logic [5:0] op, input int offw);
    return {op, 16'(offw), 5'd12, 5'd13};
  endfunction
  function automatic logic [31:0] enc_z(input logic [5:0] op, input int offw);
    logic [20:0] o = 21'(offw);
    return {op, o[15:0], 5'd4, o[20:16]};
  endfunction
  function automatic logic [31:0] enc_f(input logic [1:0] sub, input logic [2:0] sel, input int offw);
    logic [20:0] o = 21'(offw);
    return {6'b010010, o[15:0], sub, sel, o[20:16]};
  endfunction
  function automatic logic [31:0] enc_j(input logic [5:0] op, input int offw);
    logic [25:0] o = 26'(offw);
    return {op, o[15:0], o[25:16]};
  endfunction
  function automatic logic [31:0] enc_ind(input logic [4:0] src, input logic [4:0] dst, input int offw);
    return {6'b010011, 16'(offw), src, dst};
  endfunction

  function automatic logic [63:0] rel(input logic [63:0] base, input int offw);
    return base + (64'(signed'(offw)) << 2);
  endfunction

  task automatic apply(input logic [31:0] w);
    @(negedge clk);
    instr = w;
    #1;
  endtask

  task automatic t_idle;
    pc = 64'h12000600; a = '0; b = '0; flags = '0;
    apply(32'h0);
    chk("R8 reset-state illegal", 64'(illegal), 64'd1);
    chk("R8 reset-state next", next_pc, 64'h12000604);
    chk("R8 reset-state we", 64'(link_we), 64'd0);
  endtask

  task automatic t_cmp(input string tag, input logic [5:0] op,
                       input logic [63:0] va, input logic [63:0] vb, input bit exp_t);
    pc = 64'h12000600; a = va; b = vb;
    apply(enc_cmp(op, -256));
    chk({"R1 taken ", tag}, 64'(taken), 64'(exp_t));
    chk({"R1 next ", tag}, next_pc, exp_t ? 64'h12000200 : 64'h12000604);
    chk({"R1 we ", tag}, 64'(link_we), 64'd0);
  endtask

  task automatic t_zero;
    pc = 64'h12000600;
    a = 64'd0; apply(enc_z(6'b010000, -256));
    chk("R2 zero taken", next_pc, 64'h12000200);
    a = 64'd1; apply(enc_z(6'b010000, -256));
    chk("R2 zero not taken", next_pc, 64'h12000604);
    a = 64'd1; apply(enc_z(6'b010001, -256));
    chk("R2 nonzero taken", next_pc, 64'h12000200);
    a = 64'd0; apply(enc_z(6'b010001, 20'h7ffff));
    chk("R2 nonzero not taken", 64'(taken), 64'd0);
    a = 64'd5; apply(enc_z(6'b010001, 21'h0ffff + 1));
    chk("R2 high offset bits", next_pc, rel(64'h12000600, 32'h10000));
  endtask

  task automatic t_flag;
    pc = 64'h12000600;
    flags = 8'b1111_0111;
    apply(enc_f(2'b00, 3'd3, 256));
    chk("R3 flag-clear taken", next_pc, 64'h12000a00);
    apply(enc_f(2'b01, 3'd3, 256));
    chk("R3 flag-set not taken", next_pc, 64'h12000604);
    flags = 8'b0000_1000;
    apply(enc_f(2'b01, 3'd3, 256));
    chk("R3 flag-set taken", next_pc, 64'h12000a00);
    apply(enc_f(2'b00, 3'd3, 256));
    chk("R3 flag-clear not taken", 64'(taken), 64'd0);
    apply(enc_f(2'b10, 3'd3, 256));
    chk("R8 flag sub 10 illegal", 64'(illegal), 64'd1);
    chk("R8 flag sub 10 next", next_pc, 64'h12000604);
    apply(enc_f(2'b11, 3'd0, 256));
    chk("R8 flag sub 11 illegal", 64'(illegal), 64'd1);
    chk("R8 flag sub 11 taken", 64'(taken), 64'd0);
  endtask

  task automatic t_jump;
    pc = 64'h12000600;
    apply(enc_j(6'b010100, 32'h10010));
    chk("R4 jump target", next_pc, 64'h12040640);
    chk("R9 jump taken", 64'(taken), 64'd1);
    chk("R4 jump no link", 64'(link_we), 64'd0);
    apply(enc_j(6'b010101, 32'h10010));
    chk("R4 jlink target", next_pc, 64'h12040640);
    chk("R4 jlink we", 64'(link_we), 64'd1);
    chk("R4 jlink idx", 64'(link_idx), 64'd1);
    chk("R4 jlink data", link_data, 64'h12000604);
  endtask

  task automatic t_ind;
    pc = 64'h12000600; a = 64'h12000400;
    apply(enc_ind(5'd12, 5'd1, 16));
    chk("R5 ind target", next_pc, 64'h12000440);
    chk("R5 ind we", 64'(link_we), 64'd1);
    chk("R5 ind data", link_data, 64'h12000604);
    // destination equals base index
    a = 64'h0000_0000_8000_0000;
    apply(enc_ind(5'd7, 5'd7, -4));
    chk("R5 same-index target", next_pc, 64'h0000_0000_7fff_fff0);
    chk("R5 same-index idx", 64'(link_idx), 64'd7);
    chk("R9 ind taken", 64'(taken), 64'd1);
    apply(enc_ind(5'd7, 5'd0, 0));
    chk("R7 zero index no write", 64'(link_we), 64'd0);
    chk("R7 zero index still jumps", next_pc, 64'h0000_0000_8000_0000);
  endtask

  task automatic t_wrap;
    pc = 64'hFFFF_FFFF_FFFF_FFFC;
    apply(enc_j(6'b010100, 4));
    chk("R6 wrap up", next_pc, 64'h0000_0000_0000_000C);
    pc = 64'h0;
    apply(enc_j(6'b010100, -(1 << 25)));
    chk("R6 wrap down", next_pc, 64'hFFFF_FFFF_F800_0000);
    pc = 64'h1000; apply(32'hFC00_0000);
    chk("R8 opcode 111111", 64'(illegal), 64'd1);
    chk("R8 opcode 111111 next", next_pc, 64'h1004);
  endtask

  initial begin
    n_chk = 0; n_fail = 0; done = 0;
    instr = '0; pc = '0; a = '0; b = '0; flags = '0;
    t_idle();
    t_cmp("eq hit",  6'b010110, 64'd1, 64'd1, 1'b1);
    t_cmp("eq miss", 6'b010110, 64'd1, 64'd0, 1'b0);
    t_cmp("ne hit",  6'b010111, 64'd1, 64'd0, 1'b1);
    t_cmp("ne miss", 6'b010111, 64'd1, 64'd1, 1'b0);
    t_cmp("lt hit",  6'b011000, -64'sd2, 64'd1, 1'b1);
    t_cmp("lt miss", 6'b011000, -64'sd2, -64'sd3, 1'b0);
    t_cmp("ge hit",  6'b011001, -64'sd2, -64'sd3, 1'b1);
    t_cmp("ge miss", 6'b011001, -64'sd2, 64'd1, 1'b0);
    t_cmp("ltu hit", 6'b011010, -64'sd2, -64'sd1, 1'b1);
    t_cmp("ltu miss",6'b011010, -64'sd2, 64'd1, 1'b0);
    t_cmp("geu hit", 6'b011011, -64'sd2, 64'd1, 1'b1);
    t_cmp("geu miss",6'b011011, -64'sd2, -64'sd1, 1'b0);
    t_zero();
    t_flag();
    t_jump();
    t_ind();
    t_wrap();
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule